// File: doc/BRIEF.md
# Bidirectional Centre-Search Tracker

This controller follows the horizontal position of a target, such as a rail head, across successive lines of a line-scan image. The host writes an 800-pixel line as 32-bit words and then pulses `start`. The controller opens a 400-pixel window centred on the last known centre. It offers that window to an external classifier through a request/decision handshake and then moves the window outward one pixel at a time. The left search ends at the first rejected window and gives the interval begin. The right search starts again from the same centre, ends at the first rejected window and gives the interval end.

The line is held in two rotating copies. Before the search, both copies are rotated into line with the starting window. During the search, each copy turns one pixel per step in its own direction, so the window is always read from the same fixed cells. When both sides are settled, the midpoint of begin and end becomes the new centre, which is the starting point for the next line. An interrupt flag is then raised and a 64-bit result word is held for the host. The classifier and the feature extraction are outside this block.

Top module: `trk_centre_search`

## Requirements
- R1: After reset, `centre` is 512, `irq` and `cls_req` are 0, and `rd_data` is 0.
- R2: Host writes go to word address `wr_addr` (0..199). Byte lane j of the word (bits 8j+7:8j) is line pixel 4*addr+j. In `cls_win`, pixel i sits at bits 8i+7:8i and holds line pixel p-200+i, where p is the window position. A complete line must be written before each start.
- R3: The first window offered on each side is centred on the current `centre`.
- R4: The left search moves down one pixel per accepted window and stops at the first window with `cls_hit`=0. The interval begin is that rejected position.
- R5: The right search restarts at `centre`, moves up one pixel per accepted window and stops at the first rejected window. The interval end is that rejected position.
- R6: Window positions stay within 200..600. An accepted window at either limit ends that side, and the limit becomes the result for that side.
- R7: The new `centre` is floor((begin+end)/2). It is the starting point of the next search.
- R8: When both sides are done, `irq` rises and `rd_data` holds begin in bits 9:0 and end in bits 41:32. All other bits of `rd_data` are 0.
- R9: `irq` stays high until `rd_en` is sampled high, and reads 0 on the following cycle.
- R10: While a search is running, host writes and `start` pulses have no effect.
- R11: `cls_req` stays high with `cls_win` unchanged until `cls_vld` is sampled. Only one decision is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host line-word write strobe |
| wr_addr | input | 8 | Word index within the line |
| wr_data | input | 32 | Four pixels, lowest pixel in the low byte |
| start | input | 1 | Begin a search on the stored line |
| cls_req | output | 1 | Window offered to the classifier |
| cls_win | output | 3200 | 400 window pixels, pixel 0 at the LSBs |
| cls_vld | input | 1 | Classifier decision strobe |
| cls_hit | input | 1 | Decision: window is centred on the target |
| irq | output | 1 | Result ready |
| rd_en | input | 1 | Host read of the result; clears `irq` |
| rd_data | output | 64 | Packed begin and end positions |
| centre | output | 10 | Current centre estimate |

## Verification
The bench runs several targets. In one, the first window on each side is rejected, so begin, end and the centre all equal the old centre; a design that stepped before deciding would be off by one. In another, every window is accepted, so both sides run into the 200 and 600 limits; a missing clamp would read past the line and offer windows the bench never expects. Every offered window is compared pixel by pixel with the line, so any error in the rotation direction or the alignment count shows up as a shifted window. Garbage writes and extra starts issued mid-search would corrupt later windows or restart the walk if they were not ignored.

// File: rtl/trk_pkg.sv
package trk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALIGN,
      ST_LREQ,
      ST_LSTEP,
      ST_RREQ,
      ST_RSTEP,
      ST_FIN
   } trk_state_e;

   // direction a copy turns during its search steps
   typedef enum logic {
      TURN_DOWN = 1'b0,   // cell k takes cell k-1: window moves to lower positions
      TURN_UP   = 1'b1    // cell k takes cell k+1: window moves to higher positions
   } turn_e;

endpackage

// File: rtl/trk_slide_mem.sv
module trk_slide_mem
   import trk_pkg::*;
#(
   parameter int    LINE_PIX = 800,
   parameter int    WIN_PIX  = 400,
   parameter int    PIX_W    = 8,
   parameter int    BUS_W    = 32,
   parameter turn_e TURN     = TURN_DOWN,
   localparam int   PPW      = BUS_W / PIX_W,
   localparam int   WORDS    = LINE_PIX / PPW,
   localparam int   AW       = $clog2(WORDS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [BUS_W-1:0]         wr_data,
   input  logic                     align,
   input  logic                     step,
   output logic [WIN_PIX*PIX_W-1:0] win
);

   logic [LINE_PIX-1:0][PIX_W-1:0] cell_q, cell_d;
   logic [LINE_PIX-1:0][PIX_W-1:0] turn_up, turn_dn, step_src;

   assign turn_up = {cell_q[0], cell_q[LINE_PIX-1:1]};
   assign turn_dn = {cell_q[LINE_PIX-2:0], cell_q[LINE_PIX-1]};

   generate
      if (TURN == TURN_DOWN) begin : g_step_dn
         assign step_src = turn_dn;
      end else begin : g_step_up
         assign step_src = turn_up;
      end
   endgenerate

   always_comb begin
      cell_d = cell_q;
      if (align)     cell_d = turn_up;
      else if (step) cell_d = step_src;
      if (wr_en && (int'(wr_addr) < WORDS))
         cell_d[int'(wr_addr)*PPW +: PPW] = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= '0;
      else        cell_q <= cell_d;
   end

   assign win = cell_q[WIN_PIX-1:0];

   initial begin
      assert (BUS_W % PIX_W == 0) else $error("bus width must hold whole pixels");
      assert (LINE_PIX % PPW == 0) else $error("line must be whole words");
   end

   // R10
   quiet_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !align && !step) |=> $stable(win));

endmodule

// File: rtl/trk_pos_ctr.sv
module trk_pos_ctr #(
   parameter int POS_W = 10,
   parameter int LO    = 200,
   parameter int HI    = 600,
   parameter bit DOWN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [POS_W-1:0] load_val,
   input  logic             step,
   output logic [POS_W-1:0] pos,
   output logic             at_edge
);

   logic [POS_W-1:0] pos_q, pos_nxt;

   generate
      if (DOWN) begin : g_down
         assign pos_nxt = pos_q - 1'b1;
         assign at_edge = (pos_q == POS_W'(LO));
      end else begin : g_up
         assign pos_nxt = pos_q + 1'b1;
         assign at_edge = (pos_q == POS_W'(HI));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pos_q <= POS_W'(LO);
      else if (load)  pos_q <= load_val;
      else if (step)  pos_q <= pos_nxt;
   end

   assign pos = pos_q;

   initial begin
      assert (LO < HI) else $error("empty position range");
      assert (HI < (1 << POS_W)) else $error("position width too small");
   end

   // R6
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q >= POS_W'(LO)) && (pos_q <= POS_W'(HI)));

   // R6
   edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !at_edge);

endmodule

// File: rtl/trk_centre_search.sv
module trk_centre_search
   import trk_pkg::*;
#(
   parameter int  LINE_PIX = 800,
   parameter int  WIN_PIX  = 400,
   parameter int  PIX_W    = 8,
   parameter int  BUS_W    = 32,
   parameter int  RES_W    = 64,
   parameter int  INIT_CTR = 512,
   localparam int PPW      = BUS_W / PIX_W,
   localparam int WORDS    = LINE_PIX / PPW,
   localparam int AW       = $clog2(WORDS),
   localparam int POS_W    = $clog2(LINE_PIX),
   localparam int HALF     = WIN_PIX / 2,
   localparam int POS_MIN  = HALF,
   localparam int POS_MAX  = LINE_PIX - HALF,
   localparam int INIT_C   = (INIT_CTR < POS_MIN) ? POS_MIN :
                             (INIT_CTR > POS_MAX) ? POS_MAX : INIT_CTR,
   localparam int HI_OFF   = RES_W / 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [BUS_W-1:0]         wr_data,
   input  logic                     start,
   output logic                     cls_req,
   output logic [WIN_PIX*PIX_W-1:0] cls_win,
   input  logic                     cls_vld,
   input  logic                     cls_hit,
   output logic                     irq,
   input  logic                     rd_en,
   output logic [RES_W-1:0]         rd_data,
   output logic [POS_W-1:0]         centre
);

   trk_state_e       state_q, state_d;
   logic [POS_W-1:0] centre_q;
   logic [POS_W-1:0] align_cnt_q;
   logic [POS_W-1:0] align_need;
   logic             irq_q;
   logic [RES_W-1:0] res_q;

   logic             idle, launch, mem_wr, do_align, l_step, r_step;
   logic [POS_W-1:0] l_pos, r_pos;
   logic             l_edge, r_edge;
   logic [WIN_PIX*PIX_W-1:0] l_win, r_win;
   logic [POS_W:0]   pos_sum;
   logic [RES_W-1:0] res_d;

   assign idle       = (state_q == ST_IDLE);
   assign launch     = idle && start;
   assign mem_wr     = idle && wr_en;
   assign do_align   = (state_q == ST_ALIGN);
   assign l_step     = (state_q == ST_LSTEP);
   assign r_step     = (state_q == ST_RSTEP);
   assign align_need = centre_q - POS_W'(POS_MIN);

   // left-search copy turns down, right-search copy turns up
   trk_slide_mem #(
      .LINE_PIX(LINE_PIX), .WIN_PIX(WIN_PIX), .PIX_W(PIX_W),
      .BUS_W(BUS_W), .TURN(TURN_DOWN)
   ) u_mem_left (
      .clk(clk), .rst_n(rst_n), .wr_en(mem_wr), .wr_addr(wr_addr),
      .wr_data(wr_data), .align(do_align), .step(l_step), .win(l_win)
   );

   trk_slide_mem #(
      .LINE_PIX(LINE_PIX), .WIN_PIX(WIN_PIX), .PIX_W(PIX_W),
      .BUS_W(BUS_W), .TURN(TURN_UP)
   ) u_mem_right (
      .clk(clk), .rst_n(rst_n), .wr_en(mem_wr), .wr_addr(wr_addr),
      .wr_data(wr_data), .align(do_align), .step(r_step), .win(r_win)
   );

   trk_pos_ctr #(.POS_W(POS_W), .LO(POS_MIN), .HI(POS_MAX), .DOWN(1'b1)) u_pos_begin (
      .clk(clk), .rst_n(rst_n), .load(launch), .load_val(centre_q),
      .step(l_step), .pos(l_pos), .at_edge(l_edge)
   );

   trk_pos_ctr #(.POS_W(POS_W), .LO(POS_MIN), .HI(POS_MAX), .DOWN(1'b0)) u_pos_end (
      .clk(clk), .rst_n(rst_n), .load(launch), .load_val(centre_q),
      .step(r_step), .pos(r_pos), .at_edge(r_edge)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start) state_d = (align_need == '0) ? ST_LREQ : ST_ALIGN;
         ST_ALIGN: if (align_cnt_q == POS_W'(1)) state_d = ST_LREQ;
         ST_LREQ:  if (cls_vld) state_d = (!cls_hit || l_edge) ? ST_RREQ : ST_LSTEP;
         ST_LSTEP: state_d = ST_LREQ;
         ST_RREQ:  if (cls_vld) state_d = (!cls_hit || r_edge) ? ST_FIN : ST_RSTEP;
         ST_RSTEP: state_d = ST_RREQ;
         ST_FIN:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   assign pos_sum = {1'b0, l_pos} + {1'b0, r_pos};

   always_comb begin
      res_d = '0;
      res_d[POS_W-1:0]         = l_pos;
      res_d[HI_OFF +: POS_W]   = r_pos;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         centre_q    <= POS_W'(INIT_C);
         align_cnt_q <= '0;
         irq_q       <= 1'b0;
         res_q       <= '0;
      end else begin
         state_q <= state_d;
         if (launch)        align_cnt_q <= align_need;
         else if (do_align) align_cnt_q <= align_cnt_q - 1'b1;
         if (state_q == ST_FIN) begin
            centre_q <= pos_sum[POS_W:1];
            res_q    <= res_d;
            irq_q    <= 1'b1;
         end else if (rd_en) begin
            irq_q    <= 1'b0;
         end
      end
   end

   assign cls_req = (state_q == ST_LREQ) || (state_q == ST_RREQ);
   assign cls_win = (state_q == ST_RREQ) ? r_win : l_win;
   assign irq     = irq_q;
   assign rd_data = res_q;
   assign centre  = centre_q;

   initial begin
      assert (WIN_PIX % 2 == 0) else $error("window must have even width");
      assert (WIN_PIX < LINE_PIX) else $error("window wider than line");
      assert (HI_OFF >= POS_W && HI_OFF + POS_W <= RES_W) else $error("result word too narrow");
   end

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_req && !cls_vld) |=> (cls_req && $stable(cls_win)));

   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rd_en && state_q != ST_FIN) |=> irq);

   // R7
   mid_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (centre == POS_W'(({1'b0, rd_data[POS_W-1:0]} +
                                        {1'b0, rd_data[HI_OFF +: POS_W]}) >> 1)));

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !cls_req);

endmodule

// File: tb/tb_trk_centre_search.sv
module tb_trk_centre_search;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic          start = 1'b0;
   logic          cls_req;
   logic [3199:0] cls_win;
   logic          cls_vld = 1'b0;
   logic          cls_hit = 1'b0;
   logic          irq;
   logic          rd_en = 1'b0;
   logic [63:0]   rd_data;
   logic [9:0]    centre;

   trk_centre_search dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .cls_req(cls_req), .cls_win(cls_win),
      .cls_vld(cls_vld), .cls_hit(cls_hit), .irq(irq), .rd_en(rd_en),
      .rd_data(rd_data), .centre(centre)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [7:0] line_px [800];
   int tgt_lo, tgt_hi;
   int m_ctr = 512;
   int m_phase = 2;      // 0 left, 1 right, 2 settled
   int m_pos, m_beg, m_end;
   bit m_first;
   int pend_cnt = 0;
   bit pend = 1'b0;
   bit pend_hit = 1'b0;
   int req_seen = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // behavioural classifier and search model, evaluated every clock
   always @(negedge clk) begin
      cls_vld <= 1'b0;
      if (rst_n) begin
         if (pend) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
               cls_vld <= 1'b1;
               cls_hit <= pend_hit;
               pend    <= 1'b0;
            end
         end else if (cls_req) begin
            if (m_phase == 2) begin
               chk(1'b0, "R6 request after search settled", 1, 0);
            end else begin
               int bad = -1;
               for (int i = 0; i < 400; i++)
                  if (bad < 0 && cls_win[i*8 +: 8] !== line_px[m_pos - 200 + i]) bad = i;
               // R2 R3 R4 R5: offered window equals the line around the expected position
               chk(bad < 0, m_first ? "R3 first window" : (m_phase == 0 ? "R4 left window" : "R5 right window"),
                   (bad < 0) ? m_pos : cls_win[bad*8 +: 8], (bad < 0) ? m_pos : line_px[m_pos - 200 + bad]);
               pend_hit = (m_pos >= tgt_lo) && (m_pos <= tgt_hi);
               pend     <= 1'b1;
               pend_cnt = 1 + (req_seen % 3);
               req_seen++;
               m_first = 1'b0;
               if (m_phase == 0) begin
                  if (!pend_hit || m_pos == 200) begin
                     m_beg = m_pos; m_phase = 1; m_pos = m_ctr; m_first = 1'b1;
                  end else m_pos--;
               end else begin
                  if (!pend_hit || m_pos == 600) begin
                     m_end = m_pos; m_phase = 2;
                  end else m_pos++;
               end
            end
         end
      end
   end

   task automatic load_line(input int seed);
      for (int k = 0; k < 800; k++)
         line_px[k] = 8'((k * 37) + (seed * 11) + (k >> 3));
      for (int w = 0; w < 200; w++) begin
         @(negedge clk);
         wr_en   = 1'b1;
         wr_addr = 8'(w);
         wr_data = {line_px[4*w+3], line_px[4*w+2], line_px[4*w+1], line_px[4*w]};
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_search(input int lo, input int hi, input int seed, input bit poke);
      int n;
      int exp_c;
      load_line(seed);
      tgt_lo = lo; tgt_hi = hi;
      m_pos = m_ctr; m_phase = 0; m_first = 1'b1;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (poke) begin
         repeat (6) @(negedge clk);
         wr_en = 1'b1; wr_addr = 8'd3; wr_data = 32'hFFFF_FFFF; start = 1'b1;
         @(negedge clk);
         wr_addr = 8'd60; start = 1'b0;
         @(negedge clk);
         wr_en = 1'b0;
      end
      n = 0;
      while (!irq && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(irq == 1'b1, "R8 irq raised", irq, 1);
      chk(m_phase == 2, "R6 search settled", m_phase, 2);
      chk(rd_data[9:0] == 10'(m_beg), "R4 begin position", rd_data[9:0], m_beg);
      chk(rd_data[41:32] == 10'(m_end), "R5 end position", rd_data[41:32], m_end);
      chk((rd_data & ~64'h0000_03FF_0000_03FF) == 64'd0, "R8 unused bits zero", rd_data, 0);
      exp_c = (m_beg + m_end) / 2;
      chk(centre == 10'(exp_c), "R7 new centre", centre, exp_c);
      m_ctr = exp_c;
      repeat (3) @(negedge clk);
      chk(irq == 1'b1, "R9 irq held until read", irq, 1);
      chk(cls_req == 1'b0, "R10 no extra search", cls_req, 0);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(irq == 1'b0, "R9 irq cleared by read", irq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(irq == 1'b0, "R1 irq at reset", irq, 0);
      chk(cls_req == 1'b0, "R1 req at reset", cls_req, 0);
      chk(centre == 10'd512, "R1 centre at reset", centre, 512);
      chk(rd_data == 64'd0, "R1 result at reset", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(centre == 10'd512, "R1 centre after release", centre, 512);
      // R4 R5 interval around the start: begin 479, end 541, centre 510
      run_search(480, 540, 1, 1'b0);
      chk(centre == 10'd510, "R7 centre 510", centre, 510);
      // first window rejected on both sides: centre stays
      run_search(300, 350, 2, 1'b0);
      chk(centre == 10'd510, "R4 immediate reject keeps centre", centre, 510);
      // R6 everything accepted, R10 writes and start ignored mid-search
      run_search(150, 700, 3, 1'b1);
      chk(rd_data[9:0] == 10'd200, "R6 clamp at low edge", rd_data[9:0], 200);
      chk(rd_data[41:32] == 10'd600, "R6 clamp at high edge", rd_data[41:32], 600);
      // R7 narrow interval from the new centre
      run_search(380, 420, 4, 1'b0);
      chk(centre == 10'd400, "R7 centre 400", centre, 400);
      // one side clamped, other stops on reject: 200 and 451
      run_search(100, 450, 5, 1'b0);
      chk(centre == 10'd325, "R6 R7 centre 325", centre, 325);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule